// File: doc/BRIEF.md
# Silent-Store Filtering Byte Cache

This block is a small write-back cache that sits between a processor's byte load/store port and a byte-wide data SRAM whose reads return data one cycle after the enable. Every line holds a single byte. Two parameters set the shape: the set count and the associativity. One set gives a fully-associative cache, one way a direct-mapped one, and anything in between is set-associative. The default shape is 8 sets by 4 ways. The set is chosen by the low address bits, and each line keeps the full address as its tag.

Each line carries a combined modified-and-changed flag. A store raises it only when the new byte differs from the byte the line already holds. A store that rewrites an identical value is silent: it leaves the flag clear and can never cause an SRAM write. When a miss needs a line and the victim's flag is set, the victim is written back before the fill read. A clean victim is dropped with no SRAM traffic. A flush input writes out every flagged line. Four counters report SRAM reads, SRAM writes, hits and silent stores.

Requests use a valid/ready handshake. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the response has been taken, and for the whole of a flush. The response is presented with `rsp_valid`. It holds, with `rsp_rdata` unchanged, until a cycle where `rsp_ready` is high.

Top module: `ssc_top`

## Requirements
- R1: After reset, `req_ready` is high, `rsp_valid` is low, all four counters read zero, and every line is invalid, so the first access to any address misses.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` stays low while an access is in progress. Once `rsp_valid` rises, it and `rsp_rdata` stay unchanged until a cycle with `rsp_ready` high.
- R3: A load that hits returns the cached byte, makes no SRAM access, and adds one to `cnt_hit`.
- R4: A load that misses makes exactly one SRAM read of the requested address, installs that byte, and returns it.
- R5: The line index is `addr mod SETS`. A miss fills the lowest-numbered invalid way of the set. If no way is invalid, it fills the least recently used way, where both hits and fills count as uses.
- R6: A store hit with a byte equal to the cached byte leaves the line clean and adds one to `cnt_silent`. Evicting that line later causes no SRAM write.
- R7: A store hit with a different byte marks the line modified. When that line is later evicted, its byte is written to its own address in SRAM before the fill read.
- R8: A miss whose victim is clean causes no SRAM write.
- R9: A store miss reads the SRAM byte, installs the store byte, and marks the line modified only if the two bytes differ. If they are equal, it adds one to `cnt_silent` instead.
- R10: A flush pulse taken while idle writes every modified line back to SRAM, visiting one line per cycle, and leaves every line clean. A second flush then writes nothing. `req_ready` is low while `flush_busy` is high.
- R11: `cnt_sram_rd` and `cnt_sram_wr` add one for every cycle in which the SRAM port performs a read or a write, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Store byte |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 8 | Loaded byte, or the stored byte for a store |
| flush | input | 1 | Start writing back all modified lines |
| flush_busy | output | 1 | Flush walk in progress |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write (with enable) |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | 8 | SRAM write byte |
| sram_rdata | input | 8 | SRAM read byte, valid the cycle after a read |
| cnt_sram_rd | output | CNT_W | SRAM read count |
| cnt_sram_wr | output | CNT_W | SRAM write count |
| cnt_hit | output | CNT_W | Hit count |
| cnt_silent | output | CNT_W | Silent store count |

## Verification
The hardest case to reach from the ports is a modified line being chosen as the LRU victim while its set-mate was used more recently. That case shows whether the write-back goes out, and whether a silent store correctly produces none. The bench runs a 2-set, 2-way configuration over a 16-byte address space. Hand-ordered access chains fill a set, refresh one way by hitting it, and then force an eviction, so the victim is known ahead of time. Full-address sweeps then mix silent and changing stores, and a final flush compares every SRAM byte with the bench's own record of stored values.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_REFILL,
    ST_FILL,
    ST_RESP,
    ST_FLUSH
  } ssc_state_e;
endpackage

// File: rtl/ssc_match.sv
module ssc_match #(
  parameter int ADDR_W = 12,
  parameter int WAYS   = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]        vld,
  input  logic [WAYS*ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]      addr,
  output logic                   hit,
  output logic [WAY_W-1:0]       hit_way,
  output logic                   free_any,
  output logic [WAY_W-1:0]       free_way
);
  logic [WAYS-1:0] match;

  // one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld[w] && (tags[w*ADDR_W +: ADDR_W] == addr);
  end

  always_comb begin
    hit      = |match;
    free_any = ~&vld;
    hit_way  = '0;
    free_way = '0;
    // descending scan: lowest index wins
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
      if (!vld[w])  free_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/ssc_lru.sv
module ssc_lru #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] rd_set,
  output logic [WAY_W-1:0] old_way
);
  // per-set age ranks, always a permutation of 0..WAYS-1
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    old_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[rd_set][w] == WAY_W'(WAYS - 1)) old_way = WAY_W'(w);
  end
endmodule

// File: rtl/ssc_top.sv
module ssc_top
  import ssc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_rdata,
  input  logic              flush,
  output logic              flush_busy,
  output logic              sram_en,
  output logic              sram_we,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [7:0]        sram_wdata,
  input  logic [7:0]        sram_rdata,
  output logic [CNT_W-1:0]  cnt_sram_rd,
  output logic [CNT_W-1:0]  cnt_sram_wr,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_silent
);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  ssc_state_e state_q, state_d;

  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q, rdata_q;
  logic              we_q;
  logic [WAY_W-1:0]  vic_q;
  logic [IDX_W-1:0]  fl_set_q;
  logic [WAY_W-1:0]  fl_way_q;

  logic [ADDR_W-1:0] tag_q [SETS][WAYS];
  logic [7:0]        dat_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q [SETS];
  logic [WAYS-1:0]   dn_q  [SETS];

  logic [IDX_W-1:0]       idx;
  logic [WAYS*ADDR_W-1:0] set_tags;
  logic                   hit, free_any;
  logic [WAY_W-1:0]       hit_way, free_way, lru_way, vic_way;
  logic                   touch;
  logic [WAY_W-1:0]       touch_way;
  logic                   look_hit, fl_dirty, fl_last, same_hit, same_fill;

  assign idx = (SETS > 1) ? IDX_W'(addr_q) : '0;

  always_comb begin
    for (int w = 0; w < WAYS; w++) set_tags[w*ADDR_W +: ADDR_W] = tag_q[idx][w];
  end

  ssc_match #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_match (
    .vld(vld_q[idx]), .tags(set_tags), .addr(addr_q),
    .hit(hit), .hit_way(hit_way), .free_any(free_any), .free_way(free_way)
  );

  ssc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(touch), .touch_set(idx),
    .touch_way(touch_way), .rd_set(idx), .old_way(lru_way)
  );

  assign vic_way   = free_any ? free_way : lru_way;
  assign look_hit  = (state_q == ST_LOOK) && hit;
  assign touch     = look_hit || (state_q == ST_FILL);
  assign touch_way = look_hit ? hit_way : vic_q;
  assign same_hit  = look_hit && we_q && (dat_q[idx][hit_way] == wdata_q);
  assign same_fill = (state_q == ST_FILL) && we_q && (sram_rdata == wdata_q);
  assign fl_dirty  = vld_q[fl_set_q][fl_way_q] && dn_q[fl_set_q][fl_way_q];
  assign fl_last   = (fl_set_q == IDX_W'(SETS - 1)) && (fl_way_q == WAY_W'(WAYS - 1));

  assign req_ready  = (state_q == ST_IDLE) && !flush;
  assign rsp_valid  = (state_q == ST_RESP);
  assign rsp_rdata  = rdata_q;
  assign flush_busy = (state_q == ST_FLUSH);

  // next state and SRAM port
  always_comb begin
    state_d    = state_q;
    sram_en    = 1'b0;
    sram_we    = 1'b0;
    sram_addr  = addr_q;
    sram_wdata = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (flush)          state_d = ST_FLUSH;
        else if (req_valid) state_d = ST_LOOK;
      end
      ST_LOOK: begin
        if (hit) begin
          state_d = ST_RESP;
        end else if (vld_q[idx][vic_way] && dn_q[idx][vic_way]) begin
          sram_en    = 1'b1;
          sram_we    = 1'b1;
          sram_addr  = tag_q[idx][vic_way];
          sram_wdata = dat_q[idx][vic_way];
          state_d    = ST_REFILL;
        end else begin
          sram_en = 1'b1;
          state_d = ST_FILL;
        end
      end
      ST_REFILL: begin
        sram_en = 1'b1;
        state_d = ST_FILL;
      end
      ST_FILL: state_d = ST_RESP;
      ST_RESP: if (rsp_ready) state_d = ST_IDLE;
      ST_FLUSH: begin
        if (fl_dirty) begin
          sram_en    = 1'b1;
          sram_we    = 1'b1;
          sram_addr  = tag_q[fl_set_q][fl_way_q];
          sram_wdata = dat_q[fl_set_q][fl_way_q];
        end
        if (fl_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      fl_set_q <= '0;
      fl_way_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dn_q[s]  <= '0;
      end
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) begin
        fl_set_q <= '0;
        fl_way_q <= '0;
      end
      if (state_q == ST_LOOK && !hit) vic_q <= vic_way;
      if (look_hit && we_q && !same_hit) dn_q[idx][hit_way] <= 1'b1;
      if (state_q == ST_FILL) begin
        vld_q[idx][vic_q] <= 1'b1;
        dn_q[idx][vic_q]  <= we_q && !same_fill;
      end
      if (state_q == ST_FLUSH) begin
        dn_q[fl_set_q][fl_way_q] <= 1'b0;
        if (fl_way_q == WAY_W'(WAYS - 1)) begin
          fl_way_q <= '0;
          fl_set_q <= fl_set_q + 1'b1;
        end else begin
          fl_way_q <= fl_way_q + 1'b1;
        end
      end
    end
  end

  // request capture and line payload (no reset needed)
  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && req_valid && !flush) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      we_q    <= req_we;
    end
    if (look_hit) begin
      rdata_q <= we_q ? wdata_q : dat_q[idx][hit_way];
      if (we_q) dat_q[idx][hit_way] <= wdata_q;
    end
    if (state_q == ST_FILL) begin
      tag_q[idx][vic_q] <= addr_q;
      dat_q[idx][vic_q] <= we_q ? wdata_q : sram_rdata;
      rdata_q           <= we_q ? wdata_q : sram_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_sram_rd <= '0;
      cnt_sram_wr <= '0;
      cnt_hit     <= '0;
      cnt_silent  <= '0;
    end else begin
      if (sram_en && !sram_we)   cnt_sram_rd <= cnt_sram_rd + 1'b1;
      if (sram_en && sram_we)    cnt_sram_wr <= cnt_sram_wr + 1'b1;
      if (look_hit)              cnt_hit     <= cnt_hit + 1'b1;
      if (same_hit || same_fill) cnt_silent  <= cnt_silent + 1'b1;
    end
  end
endmodule

// File: rtl/ssc_chk.sv
module ssc_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [7:0]       rsp_rdata,
  input logic             flush_busy,
  input logic             sram_en,
  input logic             sram_we,
  input logic [CNT_W-1:0] cnt_sram_rd,
  input logic [CNT_W-1:0] cnt_sram_wr,
  input logic [CNT_W-1:0] cnt_hit
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R2

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R2

  AST_FLUSH_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !req_ready); // R10

  AST_HIT_NO_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
    sram_en |=> $stable(cnt_hit)); // R3

  AST_RD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    sram_en && !sram_we |=> cnt_sram_rd == $past(cnt_sram_rd) + CNT_W'(1)); // R11

  AST_WR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    sram_en && sram_we |=> cnt_sram_wr == $past(cnt_sram_wr) + CNT_W'(1)); // R11
endmodule

bind ssc_top ssc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .flush_busy(flush_busy),
  .sram_en(sram_en), .sram_we(sram_we), .cnt_sram_rd(cnt_sram_rd),
  .cnt_sram_wr(cnt_sram_wr), .cnt_hit(cnt_hit)
);

// File: tb/ssc_top_tb.sv
module ssc_top_tb;
  localparam int AW = 4;
  localparam int CW = 16;
  localparam int NA = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b0, flush = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          req_ready, rsp_valid, flush_busy, sram_en, sram_we;
  logic [7:0]    rsp_rdata, sram_wdata;
  logic [7:0]    sram_rdata = '0;
  logic [AW-1:0] sram_addr;
  logic [CW-1:0] cnt_sram_rd, cnt_sram_wr, cnt_hit, cnt_silent;

  logic [7:0] mem  [NA];
  logic [7:0] gold [NA];
  int n_chk = 0, n_bad = 0, seen_rd = 0, seen_wr = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ssc_top #(.ADDR_W(AW), .SETS(2), .WAYS(2), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .flush(flush), .flush_busy(flush_busy), .sram_en(sram_en), .sram_we(sram_we),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .cnt_sram_rd(cnt_sram_rd), .cnt_sram_wr(cnt_sram_wr), .cnt_hit(cnt_hit),
    .cnt_silent(cnt_silent)
  );

  // SRAM model: read data appears the cycle after the enable
  always @(posedge clk) begin
    if (sram_en) begin
      if (sram_we) begin mem[sram_addr] <= sram_wdata; seen_wr++; end
      else begin sram_rdata <= mem[sram_addr]; seen_rd++; end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic op(input bit we, input int a, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = AW'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r = rsp_rdata;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    if (we) gold[a] = d;
  endtask

  task automatic ld(input int a, input string req);
    logic [7:0] r;
    op(1'b0, a, 8'h00, r);
    check(req, int'(r), int'(gold[a]));
  endtask

  task automatic st(input int a, input logic [7:0] d);
    logic [7:0] r;
    op(1'b1, a, d, r);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    while (flush_busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int r0, w0, h0, s0;
    logic [7:0] v, hold;
    for (int a = 0; a < NA; a++) begin mem[a] = 8'(a * 37 + 5); gold[a] = mem[a]; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 req_ready", int'(req_ready), 1);
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 counters", int'(cnt_sram_rd | cnt_sram_wr | cnt_hit | cnt_silent), 0);

    // R4 first load misses, R1 lines invalid
    ld(0, "R4 miss data");
    check("R4 one read", int'(cnt_sram_rd), 1);
    check("R1 no hit after reset", int'(cnt_hit), 0);
    // R3 hit
    ld(0, "R3 hit data");
    check("R3 hit no read", int'(cnt_sram_rd), 1);
    check("R3 hit count", int'(cnt_hit), 1);
    // R6 silent store hit
    st(0, gold[0]);
    check("R6 silent count", int'(cnt_silent), 1);
    ld(2, "R4 fill way1");
    ld(4, "R5 evict lru");                       // victim addr0, clean
    check("R6 R8 no write on clean evict", int'(cnt_sram_wr), 0);
    check("R5 addr0 evicted", int'(cnt_sram_rd), 3);
    // R7 noisy store then eviction
    st(4, 8'hA5);
    ld(6, "R5 evict addr2");
    check("R8 clean victim", int'(cnt_sram_wr), 0);
    ld(8, "R7 evict dirty");
    check("R7 writeback count", int'(cnt_sram_wr), 1);
    check("R7 writeback value", int'(mem[4]), 'hA5);
    // R9 write miss equal value
    s0 = int'(cnt_silent); r0 = int'(cnt_sram_rd);
    st(10, gold[10]);
    check("R9 silent fill", int'(cnt_silent), s0 + 1);
    check("R9 fill read", int'(cnt_sram_rd), r0 + 1);
    ld(12, "R9 evict"); ld(14, "R9 evict");
    check("R9 clean fill no write", int'(cnt_sram_wr), 1);
    // R5 LRU refresh by hit, set 1
    r0 = int'(cnt_sram_rd); h0 = int'(cnt_hit);
    ld(1, "R5 a"); ld(3, "R5 b"); ld(1, "R5 c"); ld(5, "R5 d"); ld(1, "R5 e"); ld(3, "R5 f");
    check("R5 reads", int'(cnt_sram_rd), r0 + 4);
    check("R5 hits", int'(cnt_hit), h0 + 2);
    // R10 flush
    st(1, 8'h11); st(3, 8'h33); st(12, gold[12]);
    w0 = int'(cnt_sram_wr);
    do_flush();
    check("R10 flush writes", int'(cnt_sram_wr), w0 + 2);
    check("R10 mem1", int'(mem[1]), 'h11);
    check("R10 mem3", int'(mem[3]), 'h33);
    do_flush();
    check("R10 second flush", int'(cnt_sram_wr), w0 + 2);
    // R9 write miss with different value
    r0 = int'(cnt_sram_rd);
    st(7, 8'h3C);
    check("R9 allocate read", int'(cnt_sram_rd), r0 + 1);
    ld(9, "R9 x"); ld(11, "R9 y");
    check("R9 dirty fill written", int'(cnt_sram_wr), w0 + 3);
    check("R9 mem7", int'(mem[7]), 'h3C);
    // R2 back-pressure
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = AW'(9);
    @(negedge clk); req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    hold = rsp_rdata;
    check("R2 no accept while busy", int'(req_ready), 0);
    repeat (5) @(negedge clk);
    check("R2 valid held", int'(rsp_valid), 1);
    check("R2 data held", int'(rsp_rdata), int'(hold));
    check("R2 data", int'(rsp_rdata), int'(gold[9]));
    rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
    check("R2 released", int'(rsp_valid), 0);
    // sweep over all addresses with silent and changing stores
    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int a = 0; a < NA; a++) begin
        v = ((a + rnd) % 3 == 0) ? gold[a] : 8'(a * 11 + rnd * 29 + 1);
        st(a, v);
        ld(a, "R3 R6 R7 sweep readback");
        ld((a * 5 + rnd) % NA, "R4 R5 sweep load");
      end
    end
    do_flush();
    for (int a = 0; a < NA; a++) check("R10 sweep memory", int'(mem[a]), int'(gold[a]));
    check("R11 read count", int'(cnt_sram_rd), seen_rd);
    check("R11 write count", int'(cnt_sram_wr), seen_wr);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule